// File: doc/BRIEF.md
# Match-Triggered Watchdog Timer

This block is a watchdog timer with a small memory-mapped register bus. A free-running up-counter advances once per clock of the fixed counting clock. When software enables it, each count is compared with a programmable match value. A match can raise an interrupt flag, clear and stop the counter, change an external match pin, and start a reset request pulse on an internal and/or an external reset output. The pulse length comes from a register. A sticky status bit tells software after a restart that the watchdog caused the reset.

Software typically works as follows. It clears the counter and polls the counter register until it reads zero. It then programs the match actions, the pulse length and a match value of timeout seconds times the counting-clock rate, and enables counting. It services the watchdog by clearing and restarting the counter before the match is reached. A debug-halt input can freeze counting while a debugger holds the system. Only the power-on reset input initialises the block. The reset pulses it produces go to an external reset controller.

Top module: `match_watchdog`

## Requirements
- R1: After power-on reset (rstPor_n low), every register reads zero and intReq, extMatch, rstIntReq and rstExtReq are low.
- R2: Control register (byte offset 0x04) bit 0 set makes the counter (0x08) advance by one per clock. Writing 0 to the control register holds the counter at its value.
- R3: While control bit 1 is set, the counter is cleared on the clock after the register holds it, and it stays zero. Software polls the counter until it reads zero. Counting resumes once bit 1 is cleared.
- R4: With control bit 2 set and debugHalt high, the counter does not change.
- R5: A match occurs when the counter equals the match value (0x10) on a clock where it would advance. If match-control (0x0C) bit 0 is set, interrupt-status (0x00) bit 0 is set on that clock, and intReq follows it. Writing 1 to that bit clears it. Writing 0 leaves it unchanged. A match has priority over a clear in the same cycle.
- R6: With match-control bit 2 set, a match clears the counter and stops it. No further match occurs until control bit 1 clears the counter. Without bit 2, the counter keeps counting past the match value.
- R7: On a match, match-control bit 3 starts a pulse on rstIntReq and bit 4 starts one on rstExtReq. Each pulse begins on the clock after the match and lasts P+6 clocks, where P is the 16-bit value at 0x18. A new start during a pulse reloads the length and adds its output to the one already high.
- R8: Writing 1 to match-control bit 5 (internal) or bit 6 (external) starts the same pulse at once, from the clock of the write. Both bits read back as 0. Match-control bit 1 is reserved and reads 0.
- R9: External-match register (0x14): bit 0 is the state driven on extMatch and can be written. Bits [5:4] choose the action on a match: 0 keep, 1 drive low, 2 drive high, 3 toggle. A write in the same cycle as a match takes priority.
- R10: Reset-status (0x1C) bit 0 is set whenever a reset pulse starts. Writes to it are ignored, and only rstPor_n clears it.
- R11: Accesses are mapped only at the eight word-aligned offsets 0x00 to 0x1C. Any other address, including an unaligned one or offsets 0x20 to 0x3C, reads zero, and a write to it changes nothing. The counter register cannot be written.
- R12: busRdData reflects busAddr combinationally in the same cycle. Writes take effect at the clock edge where busWrEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rstPor_n | input | 1 | Power-on reset, active low, asynchronous |
| debugHalt | input | 1 | High while a debugger halts the system |
| busAddr | input | 6 | Byte address of the register access |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, one write per clock it is high |
| busRdData | output | 32 | Read data for busAddr |
| intReq | output | 1 | Match interrupt request |
| extMatch | output | 1 | External match pin |
| rstIntReq | output | 1 | Internal reset request pulse |
| rstExtReq | output | 1 | External reset request pulse |

## Verification
Read data is due in the same cycle as the address. A register write is visible one clock after the strobe. Interrupt, match pin and pulse starts are due one clock after the match edge. A counter clear shows up two clocks after the control write, which is why the bench polls for zero. A behavioural model in the bench takes the same inputs at each rising edge and is compared with the outputs and the read data a quarter period later. Inputs change only on falling edges. Directed reads sample two time units after setting the address, in the same cycle. The pulse width is measured by counting falling edges while the output is high.

// File: rtl/match_watchdog_pkg.sv
package match_watchdog_pkg;
  localparam int DATA_W = 32;

  // word indices of the register map
  localparam int IDX_INT   = 0;
  localparam int IDX_CTRL  = 1;
  localparam int IDX_CNT   = 2;
  localparam int IDX_MCTRL = 3;
  localparam int IDX_MATCH = 4;
  localparam int IDX_EXT   = 5;
  localparam int IDX_PULSE = 6;
  localparam int IDX_STAT  = 7;

  // fixed extra clocks added to the programmed pulse length
  localparam int PULSE_EXTRA = 6;

  typedef enum logic [1:0] {
    EXT_KEEP   = 2'd0,
    EXT_LOW    = 2'd1,
    EXT_HIGH   = 2'd2,
    EXT_TOGGLE = 2'd3
  } extAct_t;

  typedef struct packed {
    logic countEn;
    logic countClr;
    logic freezeEn;
    logic stopOnMatch;
    logic startInt;
    logic startExt;
  } dpCmd_t;
endpackage

// File: rtl/match_watchdog_ctrl.sv
module match_watchdog_ctrl
  import match_watchdog_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PULSE_W = 16,
  parameter int ADDR_W  = 6
) (
  input  logic                clk,
  input  logic                rstPor_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                busWrEn,
  input  logic [CNT_W-1:0]    count,
  input  logic                matchHit,
  output logic [DATA_W-1:0]   busRdData,
  output dpCmd_t              cmd,
  output logic [CNT_W-1:0]    matchVal,
  output logic [PULSE_W-1:0]  pulseLen,
  output logic                intReq,
  output logic                extMatch,
  output logic                wdStatus
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic wrInt, wrCtrl, wrMctrl, wrMatch, wrExt, wrPulse;

  logic [2:0] ctrlReg;
  logic       intEn, stopEn, rstIntEn, rstExtEn;
  logic       matchFlag;
  extAct_t    extAct;
  logic       extState;
  logic       forceInt, forceExt;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  assign wrInt   = busWrEn && aligned && (wordIdx == IDX_W'(IDX_INT));
  assign wrCtrl  = busWrEn && aligned && (wordIdx == IDX_W'(IDX_CTRL));
  assign wrMctrl = busWrEn && aligned && (wordIdx == IDX_W'(IDX_MCTRL));
  assign wrMatch = busWrEn && aligned && (wordIdx == IDX_W'(IDX_MATCH));
  assign wrExt   = busWrEn && aligned && (wordIdx == IDX_W'(IDX_EXT));
  assign wrPulse = busWrEn && aligned && (wordIdx == IDX_W'(IDX_PULSE));

  assign forceInt = wrMctrl && busWrData[5];
  assign forceExt = wrMctrl && busWrData[6];

  always_comb begin
    cmd.countEn     = ctrlReg[0];
    cmd.countClr    = ctrlReg[1];
    cmd.freezeEn    = ctrlReg[2];
    cmd.stopOnMatch = stopEn;
    cmd.startInt    = forceInt || (matchHit && rstIntEn);
    cmd.startExt    = forceExt || (matchHit && rstExtEn);
  end

  always_ff @(posedge clk or negedge rstPor_n) begin
    if (!rstPor_n) begin
      ctrlReg   <= '0;
      intEn     <= 1'b0;
      stopEn    <= 1'b0;
      rstIntEn  <= 1'b0;
      rstExtEn  <= 1'b0;
      matchFlag <= 1'b0;
      matchVal  <= '0;
      extAct    <= EXT_KEEP;
      extState  <= 1'b0;
      pulseLen  <= '0;
      wdStatus  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= busWrData[2:0];
      if (wrMctrl) begin
        intEn    <= busWrData[0];
        stopEn   <= busWrData[2];
        rstIntEn <= busWrData[3];
        rstExtEn <= busWrData[4];
      end
      if (wrMatch) matchVal <= busWrData[CNT_W-1:0];
      if (wrPulse) pulseLen <= busWrData[PULSE_W-1:0];

      if (matchHit && intEn) matchFlag <= 1'b1;
      else if (wrInt && busWrData[0]) matchFlag <= 1'b0;

      if (wrExt) begin
        extAct   <= extAct_t'(busWrData[5:4]);
        extState <= busWrData[0];
      end else if (matchHit) begin
        case (extAct)
          EXT_LOW:    extState <= 1'b0;
          EXT_HIGH:   extState <= 1'b1;
          EXT_TOGGLE: extState <= ~extState;
          default:    extState <= extState;
        endcase
      end

      if (cmd.startInt || cmd.startExt) wdStatus <= 1'b1;
    end
  end

  assign intReq   = matchFlag;
  assign extMatch = extState;

  always_comb begin
    busRdData = '0;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(IDX_INT):   busRdData[0] = matchFlag;
        IDX_W'(IDX_CTRL):  busRdData[2:0] = ctrlReg;
        IDX_W'(IDX_CNT):   busRdData[CNT_W-1:0] = count;
        IDX_W'(IDX_MCTRL): busRdData[4:0] = {rstExtEn, rstIntEn, stopEn, 1'b0, intEn};
        IDX_W'(IDX_MATCH): busRdData[CNT_W-1:0] = matchVal;
        IDX_W'(IDX_EXT):   busRdData[5:0] = {extAct, 3'b000, extState};
        IDX_W'(IDX_PULSE): busRdData[PULSE_W-1:0] = pulseLen;
        IDX_W'(IDX_STAT):  busRdData[0] = wdStatus;
        default:           busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/match_watchdog_dp.sv
module match_watchdog_dp
  import match_watchdog_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PULSE_W = 16
) (
  input  logic               clk,
  input  logic               rstPor_n,
  input  logic               debugHalt,
  input  dpCmd_t             cmd,
  input  logic [CNT_W-1:0]   matchVal,
  input  logic [PULSE_W-1:0] pulseLen,
  output logic [CNT_W-1:0]   count,
  output logic               matchHit,
  output logic               rstIntReq,
  output logic               rstExtReq
);
  localparam int LEFT_W = PULSE_W + 1;
  localparam logic [LEFT_W-1:0] EXTRA = LEFT_W'(PULSE_EXTRA);

  logic              stopped;
  logic              active;
  logic [LEFT_W-1:0] pulseLeft;
  logic              pulseOn;
  logic              selInt, selExt;

  assign active   = cmd.countEn && !cmd.countClr && !stopped &&
                    !(cmd.freezeEn && debugHalt);
  assign matchHit = active && (count == matchVal);
  assign pulseOn  = (pulseLeft != '0);

  always_ff @(posedge clk or negedge rstPor_n) begin
    if (!rstPor_n) begin
      count   <= '0;
      stopped <= 1'b0;
    end else if (cmd.countClr) begin
      count   <= '0;
      stopped <= 1'b0;
    end else if (matchHit && cmd.stopOnMatch) begin
      count   <= '0;
      stopped <= 1'b1;
    end else if (active) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstPor_n) begin
    if (!rstPor_n) begin
      pulseLeft <= '0;
      selInt    <= 1'b0;
      selExt    <= 1'b0;
    end else if (cmd.startInt || cmd.startExt) begin
      pulseLeft <= {1'b0, pulseLen} + EXTRA;
      selInt    <= (pulseOn && selInt) || cmd.startInt;
      selExt    <= (pulseOn && selExt) || cmd.startExt;
    end else if (pulseOn) begin
      pulseLeft <= pulseLeft - 1'b1;
    end
  end

  assign rstIntReq = pulseOn && selInt;
  assign rstExtReq = pulseOn && selExt;
endmodule

// File: rtl/match_watchdog.sv
module match_watchdog
  import match_watchdog_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PULSE_W = 16,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rstPor_n,
  input  logic              debugHalt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              busWrEn,
  output logic [31:0]       busRdData,
  output logic              intReq,
  output logic              extMatch,
  output logic              rstIntReq,
  output logic              rstExtReq
);
  dpCmd_t             cmd;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   matchVal;
  logic [PULSE_W-1:0] pulseLen;
  logic               matchHit;
  logic               wdStatus;

  match_watchdog_ctrl #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstPor_n(rstPor_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .count(count), .matchHit(matchHit), .busRdData(busRdData),
    .cmd(cmd), .matchVal(matchVal), .pulseLen(pulseLen), .intReq(intReq),
    .extMatch(extMatch), .wdStatus(wdStatus)
  );

  match_watchdog_dp #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_dp (
    .clk(clk), .rstPor_n(rstPor_n), .debugHalt(debugHalt), .cmd(cmd),
    .matchVal(matchVal), .pulseLen(pulseLen), .count(count), .matchHit(matchHit),
    .rstIntReq(rstIntReq), .rstExtReq(rstExtReq)
  );
endmodule

// File: rtl/match_watchdog_chk.sv
module match_watchdog_chk
  import match_watchdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstPor_n,
  input logic             debugHalt,
  input dpCmd_t           cmd,
  input logic [CNT_W-1:0] count,
  input logic             matchHit,
  input logic             intReq,
  input logic             rstIntReq,
  input logic             rstExtReq,
  input logic             wdStatus
);
  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rstPor_n)
    (!cmd.countEn && !cmd.countClr) |=> $stable(count));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rstPor_n)
    cmd.countClr |=> (count == '0));

  assert_debug_freeze_R4: assert property (@(posedge clk) disable iff (!rstPor_n)
    (cmd.freezeEn && debugHalt && !cmd.countClr) |=> $stable(count));

  assert_irq_from_match_R5: assert property (@(posedge clk) disable iff (!rstPor_n)
    $rose(intReq) |-> $past(matchHit));

  assert_stop_on_match_R6: assert property (@(posedge clk) disable iff (!rstPor_n)
    (matchHit && cmd.stopOnMatch) |=> (count == '0));

  assert_int_pulse_start_R7: assert property (@(posedge clk) disable iff (!rstPor_n)
    cmd.startInt |=> rstIntReq);

  assert_ext_pulse_start_R7: assert property (@(posedge clk) disable iff (!rstPor_n)
    cmd.startExt |=> rstExtReq);

  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rstPor_n)
    !$fell(wdStatus));

  assert_status_with_pulse_R10: assert property (@(posedge clk) disable iff (!rstPor_n)
    (rstIntReq || rstExtReq) |-> wdStatus);
endmodule

bind match_watchdog match_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstPor_n(rstPor_n), .debugHalt(debugHalt), .cmd(cmd), .count(count),
  .matchHit(matchHit), .intReq(intReq), .rstIntReq(rstIntReq), .rstExtReq(rstExtReq),
  .wdStatus(wdStatus)
);

// File: tb/match_watchdog_bench.sv
module match_watchdog_bench;
  logic        clk = 1'b0;
  logic        rstPor_n = 1'b0;
  logic        debugHalt = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busRdData;
  logic        intReq, extMatch, rstIntReq, rstExtReq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  match_watchdog u_match_watchdog (
    .clk(clk), .rstPor_n(rstPor_n), .debugHalt(debugHalt), .busAddr(busAddr),
    .busWrData(busWrData), .busWrEn(busWrEn), .busRdData(busRdData), .intReq(intReq),
    .extMatch(extMatch), .rstIntReq(rstIntReq), .rstExtReq(rstExtReq)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mCount, mMatch;
  logic        mStopped, mFlag, mIntEn, mStopEn, mRi, mRe, mState, mStatus, mSelI, mSelE;
  logic [2:0]  mCtrl;
  logic [1:0]  mAct;
  logic [15:0] mPlen;
  int          mLeft;

  function automatic logic [31:0] mRead(input logic [5:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[5:2])
      4'd0: return {31'h0, mFlag};
      4'd1: return {29'h0, mCtrl};
      4'd2: return mCount;
      4'd3: return {27'h0, mRe, mRi, mStopEn, 1'b0, mIntEn};
      4'd4: return mMatch;
      4'd5: return {26'h0, mAct, 3'b000, mState};
      4'd6: return {16'h0, mPlen};
      4'd7: return {31'h0, mStatus};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstPor_n) begin
    if (!rstPor_n) begin
      mCount = 0; mMatch = 0; mStopped = 0; mFlag = 0; mIntEn = 0; mStopEn = 0;
      mRi = 0; mRe = 0; mState = 0; mStatus = 0; mSelI = 0; mSelE = 0;
      mCtrl = 0; mAct = 0; mPlen = 0; mLeft = 0;
    end else begin
      bit wr, act, hit, sI, sE;
      int wi;
      wr  = busWrEn && (busAddr[1:0] == 2'b00);
      wi  = int'(busAddr[5:2]);
      act = mCtrl[0] && !mCtrl[1] && !mStopped && !(mCtrl[2] && debugHalt);
      hit = act && (mCount == mMatch);
      sI  = (hit && mRi) || (wr && wi == 3 && busWrData[5]);
      sE  = (hit && mRe) || (wr && wi == 3 && busWrData[6]);
      if (mCtrl[1]) begin mCount = 0; mStopped = 0; end
      else if (hit && mStopEn) begin mCount = 0; mStopped = 1; end
      else if (act) mCount = mCount + 1;
      if (hit && mIntEn) mFlag = 1;
      else if (wr && wi == 0 && busWrData[0]) mFlag = 0;
      if (wr && wi == 5) begin mAct = busWrData[5:4]; mState = busWrData[0]; end
      else if (hit) begin
        if (mAct == 2'd1) mState = 0;
        else if (mAct == 2'd2) mState = 1;
        else if (mAct == 2'd3) mState = !mState;
      end
      if (sI || sE) begin
        mSelI = (mLeft != 0 && mSelI) || sI;
        mSelE = (mLeft != 0 && mSelE) || sE;
        mLeft = int'(mPlen) + 6;
        mStatus = 1;
      end else if (mLeft != 0) mLeft = mLeft - 1;
      if (wr && wi == 1) mCtrl = busWrData[2:0];
      if (wr && wi == 3) begin
        mIntEn = busWrData[0]; mStopEn = busWrData[2]; mRi = busWrData[3]; mRe = busWrData[4];
      end
      if (wr && wi == 4) mMatch = busWrData;
      if (wr && wi == 6) mPlen = busWrData[15:0];
    end
  end

  always @(posedge clk) begin
    #5;
    check("R12 rdData", busRdData, mRead(busAddr));
    check("R5 intReq", {31'h0, intReq}, {31'h0, mFlag});
    check("R9 extMatch", {31'h0, extMatch}, {31'h0, mState});
    check("R7 rstIntReq", {31'h0, rstIntReq}, {31'h0, (mLeft != 0) && mSelI});
    check("R7 rstExtReq", {31'h0, rstExtReq}, {31'h0, (mLeft != 0) && mSelE});
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rdGet(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #2;
    v = busRdData;
  endtask

  task automatic rdChk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rdGet(a, v);
    check(tag, v, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearCounter();
    logic [31:0] v;
    int tries = 0;
    wr(6'h04, 32'h2);
    rdGet(6'h08, v);
    while (v != 0 && tries < 20) begin
      rdGet(6'h08, v);
      tries++;
    end
    check("R3 counter polls to zero", v, 32'h0);
  endtask

  task automatic waitHigh(ref logic sig, input string tag);
    int n = 0;
    @(negedge clk);
    while (!sig && n < 200) begin @(negedge clk); n++; end
    check(tag, {31'h0, sig}, 32'h1);
  endtask

  task automatic pulseWidth(ref logic sig, input int exp, input string tag);
    int n = 0;
    while (sig && n < 100) begin n++; @(negedge clk); end
    check(tag, n, exp);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] v1, v2;
    idle(3);
    // R1 reset state
    for (int i = 0; i < 8; i++) rdChk(6'(i * 4), 32'h0, "R1 register reset value");
    check("R1 outputs low", {28'h0, intReq, extMatch, rstIntReq, rstExtReq}, 32'h0);
    @(negedge clk); rstPor_n = 1'b1;
    idle(2);
    check("R1 outputs low after release", {28'h0, intReq, extMatch, rstIntReq, rstExtReq}, 32'h0);

    // R2 counting and holding
    wr(6'h04, 32'h1);
    idle(3);
    rdGet(6'h08, v1);
    idle(3);
    rdGet(6'h08, v2);
    check("R2 counter advances one per clock", v2, v1 + 32'd4);
    wr(6'h04, 32'h0);
    rdGet(6'h08, v1);
    idle(4);
    rdGet(6'h08, v2);
    check("R2 counter holds when disabled", v2, v1);

    // R3 clear, then program a stop-on-match with internal reset
    clearCounter();
    wr(6'h18, 32'd3);
    wr(6'h10, 32'd20);
    wr(6'h0C, 32'h0D);
    wr(6'h14, 32'h20);
    wr(6'h00, 32'h1);
    wr(6'h04, 32'h1);
    waitHigh(rstIntReq, "R7 internal pulse starts on match");
    pulseWidth(rstIntReq, 9, "R7 internal pulse length P+6");
    check("R5 interrupt raised", {31'h0, intReq}, 32'h1);
    rdChk(6'h00, 32'h1, "R5 interrupt flag reads set");
    rdChk(6'h08, 32'h0, "R6 counter stopped at zero");
    idle(3);
    rdChk(6'h08, 32'h0, "R6 no restart after stop");
    check("R9 match drove pin high", {31'h0, extMatch}, 32'h1);
    rdChk(6'h14, 32'h21, "R9 external match register");
    rdChk(6'h1C, 32'h1, "R10 watchdog status set");
    rdChk(6'h0C, 32'h0D, "R8 match control readback");
    check("R7 no external pulse", {31'h0, rstExtReq}, 32'h0);

    // R5 clear behaviour, R10 write ignored
    wr(6'h00, 32'h0);
    rdChk(6'h00, 32'h1, "R5 write 0 keeps flag");
    wr(6'h00, 32'h1);
    rdChk(6'h00, 32'h0, "R5 write 1 clears flag");
    check("R5 intReq dropped", {31'h0, intReq}, 32'h0);
    wr(6'h1C, 32'h0);
    rdChk(6'h1C, 32'h1, "R10 status write ignored");

    // R4 debug freeze
    clearCounter();
    wr(6'h04, 32'h5);
    idle(3);
    @(negedge clk); debugHalt = 1'b1;
    rdGet(6'h08, v1);
    idle(6);
    rdGet(6'h08, v2);
    check("R4 counter frozen in debug", v2, v1);
    @(negedge clk); debugHalt = 1'b0;
    idle(2);
    rdGet(6'h08, v2);
    check("R4 counting resumes", {31'h0, v2 > v1}, 32'h1);

    // R6 continue past match, R9 toggle, R7 external pulse
    wr(6'h0C, 32'h10);
    wr(6'h10, 32'd5);
    wr(6'h14, 32'h30);
    clearCounter();
    wr(6'h04, 32'h1);
    waitHigh(rstExtReq, "R7 external pulse starts on match");
    pulseWidth(rstExtReq, 9, "R7 external pulse length P+6");
    check("R9 toggle drove pin high", {31'h0, extMatch}, 32'h1);
    rdGet(6'h08, v1);
    check("R6 counter keeps counting past match", {31'h0, v1 > 32'd5}, 32'h1);

    // R8 forced pulses
    wr(6'h0C, 32'h40);
    check("R8 forced external pulse", {31'h0, rstExtReq}, 32'h1);
    check("R8 no internal pulse", {31'h0, rstIntReq}, 32'h0);
    rdChk(6'h0C, 32'h0, "R8 force bits read zero");
    wr(6'h0C, 32'h20);
    check("R8 forced internal pulse", {31'h0, rstIntReq}, 32'h1);
    idle(12);

    // R11 unmapped and read-only
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h05, 32'h0);
    wr(6'h11, 32'h0);
    rdChk(6'h20, 32'h0, "R11 unmapped read zero");
    rdChk(6'h3C, 32'h0, "R11 unmapped read zero");
    rdChk(6'h06, 32'h0, "R11 unaligned read zero");
    rdChk(6'h04, 32'h1, "R11 unaligned write ignored");
    rdChk(6'h10, 32'd5, "R11 match unchanged");
    rdGet(6'h08, v1);
    wr(6'h08, 32'h0);
    rdGet(6'h08, v2);
    check("R11 counter write ignored", {31'h0, v2 > v1}, 32'h1);

    // R10 cleared only by power-on reset, R1 again
    @(negedge clk); rstPor_n = 1'b0;
    idle(2);
    @(negedge clk); rstPor_n = 1'b1;
    rdChk(6'h1C, 32'h0, "R10 status cleared by power-on reset");
    rdChk(6'h04, 32'h0, "R1 control reset");
    idle(2);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    done = 1;
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule